// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a countdown timer that sits on a simple 32-bit register bus. Software places a start value in a load register, chooses a tick source and an underflow behaviour in a control register, and sets the enable bit. The counter then drops by one on each pulse of the selected tick strobe. When it counts down past zero it either reloads from the load register (periodic mode) or wraps to all ones (free-running mode). In both modes it raises an interrupt request that stays high until software writes to the clear address.

Two tick strobes come from an external prescaler, a fast one and a slow one. The timer only selects between them and does not generate them. The counter width is a parameter: 16 bits for the small instances and 32 bits for the large one. Reads return the count zero-extended to the bus width.

Top module: `dtmr_timer`

## Requirements
- R1: After synchronous reset the counter, the load register and the control register are all zero, `irq_o` is low and `bus_rdata` is zero.
- R2: Address bits [3:2] select the register: 0x0 is the load register, 0x4 is the live count (read only, writes have no effect), 0x8 is control and 0xC is clear. `bus_rdata` is registered and shows the selected register in the cycle after `bus_rd`.
- R3: A write to the load register stores the value and also copies it into the counter at the same clock edge. This write takes priority over a tick in that cycle, and no underflow occurs.
- R4: Control bit 7 is the enable, bit 6 selects periodic mode (1) or free-running mode (0), and bit 3 selects the fast tick (1) or the slow tick (0). A read of control returns these bits in the same positions and zeros in all other bits.
- R5: While the timer is enabled, the counter decrements by one on each cycle in which the selected tick strobe is high. The other strobe has no effect.
- R6: In periodic mode, a selected tick that arrives while the count is zero reloads the counter from the load register.
- R7: In free-running mode, a selected tick that arrives while the count is zero sets the counter to all ones.
- R8: An underflow sets `irq_o` at the following edge, and `irq_o` stays high until it is cleared.
- R9: A write of any data to the clear address drops `irq_o` at the next edge. If an underflow happens in the same cycle, `irq_o` stays set.
- R10: While the enable bit is 0, ticks leave the counter and `irq_o` unchanged. Writing 0 to control therefore stops the timer.
- R11: A read of the count returns the CNT_W-bit value zero-extended to 32 bits. Load data is truncated to CNT_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_fast | input | 1 | Fast tick strobe from the prescaler |
| tick_slow | input | 1 | Slow tick strobe from the prescaler |
| irq_o | output | 1 | Sticky underflow interrupt request |

## Verification
The bound checker tests the step rules on every cycle:
- a load write takes precedence,
- the counter decrements on the selected tick,
- the counter reloads or wraps at zero,
- the counter holds while disabled,
- the interrupt stays sticky,
- an underflow in the same cycle wins over a clear.

Some behaviour is visible only through the bench's scenarios: the register address map, the bit positions in the control read-back, the one-cycle read latency, zero extension of the count, and the reset state. The bench covers these with a table of bus operations and directed tests of the same-cycle collisions.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = 2;

  // word index = bus_addr[3:2]
  localparam logic [IDX_W-1:0] IDX_LOAD  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_VALUE = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 2'd2;
  localparam logic [IDX_W-1:0] IDX_CLEAR = 2'd3;

  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef struct packed {
    logic en;
    logic periodic;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/dtmr_regif.sv
`timescale 1ns/1ps
module dtmr_regif
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output logic              load_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [IDX_W-1:0]  widx;
  logic              ctrl_wr;
  logic [DATA_W-1:0] load_ext;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] ctrl_rd;
  logic [DATA_W-1:0] rd_mux;

  assign widx    = bus_addr[3:2];
  assign load_wr = bus_wr && (widx == IDX_LOAD);
  assign ctrl_wr = bus_wr && (widx == IDX_CTRL);
  assign clr_wr  = bus_wr && (widx == IDX_CLEAR);

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign load_ext = {{(DATA_W-CNT_W){1'b0}}, load_q};
      assign cnt_ext  = {{(DATA_W-CNT_W){1'b0}}, cnt};
    end else begin : g_full
      assign load_ext = load_q;
      assign cnt_ext  = cnt;
    end
  endgenerate

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[BIT_EN]   = ctrl_q.en;
    ctrl_rd[BIT_PER]  = ctrl_q.periodic;
    ctrl_rd[BIT_FAST] = ctrl_q.fast;
  end

  always_comb begin
    case (widx)
      IDX_LOAD:  rd_mux = load_ext;
      IDX_VALUE: rd_mux = cnt_ext;
      IDX_CTRL:  rd_mux = ctrl_rd;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q    <= '0;
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (load_wr) load_q <= bus_wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl_q.en       <= bus_wdata[BIT_EN];
        ctrl_q.periodic <= bus_wdata[BIT_PER];
        ctrl_q.fast     <= bus_wdata[BIT_FAST];
      end
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};
endmodule

// File: rtl/dtmr_count.sv
`timescale 1ns/1ps
module dtmr_count
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uf
);
  logic tick_sel;
  logic step;

  assign tick_sel = ctrl.fast ? tick_fast : tick_slow;
  assign step     = ctrl.en && tick_sel && !load_wr;
  assign uf       = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_wr) begin
      cnt_q <= load_data;
    end else if (step) begin
      if (cnt_q == '0) cnt_q <= ctrl.periodic ? reload_val : '1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dtmr_irq.sv
`timescale 1ns/1ps
module dtmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end
endmodule

// File: rtl/dtmr_timer.sv
`timescale 1ns/1ps
module dtmr_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             load_wr;
  logic             clr_wr;
  logic             uf;
  logic             ctrl_en;
  logic             ctrl_per;
  logic             ctrl_fast;

  assign ctrl_en   = ctrl_q.en;
  assign ctrl_per  = ctrl_q.periodic;
  assign ctrl_fast = ctrl_q.fast;

  dtmr_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
    .load_q(load_q), .ctrl_q(ctrl_q), .load_wr(load_wr),
    .clr_wr(clr_wr), .bus_rdata(bus_rdata)
  );

  dtmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .load_wr(load_wr),
    .load_data(bus_wdata[CNT_W-1:0]), .reload_val(load_q),
    .cnt_q(cnt_q), .uf(uf)
  );

  dtmr_irq u_irq (
    .clk(clk), .rst(rst), .set_i(uf), .clr_i(clr_wr), .irq_q(irq_o)
  );
endmodule

// File: rtl/dtmr_chk.sv
`timescale 1ns/1ps
module dtmr_chk
  import dtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              tick_fast,
  input logic              tick_slow,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  load_q,
  input logic              ctrl_en,
  input logic              ctrl_per,
  input logic              ctrl_fast
);
  logic ld_w, clr_w, tk, go, zero;
  assign ld_w  = bus_wr && (bus_addr[3:2] == IDX_LOAD);
  assign clr_w = bus_wr && (bus_addr[3:2] == IDX_CLEAR);
  assign tk    = ctrl_fast ? tick_fast : tick_slow;
  assign go    = ctrl_en && tk && !ld_w;
  assign zero  = (cnt_q == '0);

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    ld_w |=> cnt_q == $past(bus_wdata[CNT_W-1:0])); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    go && !zero |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_PER_RELOAD: assert property (@(posedge clk) disable iff (rst)
    go && zero && ctrl_per |=> cnt_q == $past(load_q)); // R6
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    go && zero && !ctrl_per |=> &cnt_q); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    go && zero |=> irq_o); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    irq_o && !clr_w |=> irq_o); // R8
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    clr_w && !(go && zero) |=> !irq_o); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en && !ld_w |=> $stable(cnt_q)); // R10
  AST_NO_SPUR_IRQ: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en && !irq_o |=> !irq_o); // R10
endmodule

bind dtmr_timer dtmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tick_fast(tick_fast), .tick_slow(tick_slow),
  .irq_o(irq_o), .cnt_q(cnt_q), .load_q(load_q), .ctrl_en(ctrl_en),
  .ctrl_per(ctrl_per), .ctrl_fast(ctrl_fast)
);

// File: tb/dtmr_timer_bench.sv
`timescale 1ns/1ps
module dtmr_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TF = 3'd2,
                         OP_TS = 3'd3, OP_IRQ = 3'd4;
  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'h0, 32'd3,        32'd0,        4'd3},  // R3 load 3
    '{OP_RD, 4'h4, 32'd0,        32'd3,        4'd3},  // R3 count copied
    '{OP_RD, 4'h0, 32'd0,        32'd3,        4'd2},  // R2 load readback
    '{OP_WR, 4'h8, 32'hFFFF_FFC8,32'd0,        4'd4},  // R4 en,periodic,fast
    '{OP_RD, 4'h8, 32'd0,        32'h0000_00C8,4'd4},  // R4 only bits 7,6,3
    '{OP_TF, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_RD, 4'h4, 32'd0,        32'd2,        4'd5},  // R5 decrement
    '{OP_TS, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_RD, 4'h4, 32'd0,        32'd2,        4'd5},  // R5 slow ignored
    '{OP_TF, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_TF, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_RD, 4'h4, 32'd0,        32'd0,        4'd5},  // R5 reached 0
    '{OP_IRQ,4'h0, 32'd0,        32'd0,        4'd8},  // R8 no irq yet
    '{OP_TF, 4'h0, 32'd0,        32'd0,        4'd6},
    '{OP_RD, 4'h4, 32'd0,        32'd3,        4'd6},  // R6 reload
    '{OP_IRQ,4'h0, 32'd0,        32'd1,        4'd8},  // R8 set
    '{OP_TF, 4'h0, 32'd0,        32'd0,        4'd8},
    '{OP_IRQ,4'h0, 32'd0,        32'd1,        4'd8},  // R8 sticky
    '{OP_WR, 4'hC, 32'h1234_5678,32'd0,        4'd9},
    '{OP_IRQ,4'h0, 32'd0,        32'd0,        4'd9},  // R9 cleared
    '{OP_WR, 4'h8, 32'h0000_0080,32'd0,        4'd4},  // free, slow
    '{OP_RD, 4'h4, 32'd0,        32'd2,        4'd5},
    '{OP_TF, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_RD, 4'h4, 32'd0,        32'd2,        4'd5},  // R5 fast ignored
    '{OP_TS, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_TS, 4'h0, 32'd0,        32'd0,        4'd5},
    '{OP_TS, 4'h0, 32'd0,        32'd0,        4'd7},
    '{OP_RD, 4'h4, 32'd0,        32'h0000_FFFF,4'd7},  // R7 wrap
    '{OP_IRQ,4'h0, 32'd0,        32'd1,        4'd8},  // R8 on wrap
    '{OP_WR, 4'hC, 32'd0,        32'd0,        4'd9},
    '{OP_WR, 4'h8, 32'd0,        32'd0,        4'd10},
    '{OP_TS, 4'h0, 32'd0,        32'd0,        4'd10},
    '{OP_RD, 4'h4, 32'd0,        32'h0000_FFFF,4'd10}  // R10 held
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tick_fast = 1'b0, tick_slow = 1'b0;
  logic irq_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmr_timer #(.CNT_W(CNT_W), .DATA_W(32)) u_dtmr_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic tick(input logic f, input logic s);
    @(negedge clk); tick_fast = f; tick_slow = s;
    @(negedge clk); tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    string tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(4'h0, d); check("R1 load", d, 32'd0);
    rd(4'h4, d); check("R1 count", d, 32'd0);
    rd(4'h8, d); check("R1 ctrl", d, 32'd0);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WR: wr(VECS[i].addr, VECS[i].data);
        OP_RD: begin rd(VECS[i].addr, d); check(tag, d, VECS[i].exp); end
        OP_TF: tick(1'b1, 1'b0);
        OP_TS: tick(1'b0, 1'b1);
        default: check(tag, {31'd0, irq_o}, VECS[i].exp);
      endcase
    end

    // R11 zero extension and truncation
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R11 count zero-extended", d, 32'h0000_FFFF);
    rd(4'h0, d); check("R11 load truncated", d, 32'h0000_FFFF);

    // R2 write to count address has no effect
    wr(4'h4, 32'h0000_0055);
    rd(4'h4, d); check("R2 count write ignored", d, 32'h0000_FFFF);

    // R9 underflow and clear in the same cycle: set wins
    wr(4'h0, 32'd0);
    wr(4'h8, 32'h0000_00C8);
    @(negedge clk); tick_fast = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'd9;
    @(negedge clk); tick_fast = 1'b0; bus_wr = 1'b0;
    check("R9 set beats clear", {31'd0, irq_o}, 32'd1);
    wr(4'hC, 32'd0);
    check("R9 clear after collision", {31'd0, irq_o}, 32'd0);

    // R3 load write beats a tick in the same cycle, no underflow
    @(negedge clk); tick_fast = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'd7;
    @(negedge clk); tick_fast = 1'b0; bus_wr = 1'b0;
    check("R3 no underflow on load", {31'd0, irq_o}, 32'd0);
    rd(4'h4, d); check("R3 load beats tick", d, 32'd7);

    // R10 disabling keeps a pending irq
    wr(4'h0, 32'd0);
    tick(1'b1, 1'b0);
    wr(4'h8, 32'd0);
    tick(1'b1, 1'b1);
    check("R10 irq kept while disabled", {31'd0, irq_o}, 32'd1);
    rd(4'h4, d); check("R10 count held", d, 32'd0);

    finish_run();
  end
endmodule